// File: doc/BRIEF.md
# Chained Receive Byte Buffer

This block buffers bytes from a serial receiver until a slower consumer can take them. Its capacity is not one deep memory with head and tail pointers. It is a chain of small first-word-fall-through FIFO stages. The producer writes into the head stage, and the consumer reads from the tail stage. Between each pair of neighbouring stages sits a link controller. The link moves one byte forward when the upstream stage holds data and the downstream stage has room.

With the default configuration, five stages of sixteen bytes give eighty bytes of storage. That is enough to ride out a consumer stall of several milliseconds at the fastest common serial rate. Every stage reports its own full flag, so a row of indicators shows how far the backlog has grown. A sticky overflow flag records any byte lost because the head stage was full.

Top module: `rxq_cascade`

## Requirements
- R1: With N stages of depth D and k bytes held, once the chain has settled, stage i (stage 0 is the head) reports full exactly when k >= D*(N-i). The chain holds up to N*D bytes.
- R2: Bytes leave in the order in which the producer wrote them, with no duplicates and no gaps.
- R3: A link moves a byte only when its source stage holds data and its destination stage is not full. Each move is a one-cycle read pulse on the source and a one-cycle write pulse on the destination, in the same cycle.
- R4: A link never moves bytes in two consecutive cycles. This gives the source's registered data-present flag one cycle to fall.
- R5: A byte written into an empty chain raises the data-available output after the N-th rising edge, counting the edge that accepts the write. Data-available stays low after every earlier edge.
- R6: A write while the head stage is full is dropped. It sets the overflow output, which then stays high until reset.
- R7: A read request while data-available is low has no effect on the buffered contents.
- R8: Synchronous reset (active high) empties every stage and clears every link and the overflow flag.
- R9: While data-available is high, the read-data output already shows the oldest byte. A read pulse consumes that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Producer write strobe |
| wr_data | input | WIDTH | Producer byte |
| rd_en | input | 1 | Consumer read strobe |
| rd_data | output | WIDTH | Oldest byte, valid while data_avail is high |
| data_avail | output | 1 | Tail stage holds data |
| stage_full | output | NUM_STAGES | Full flag of each stage, bit i for stage i |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
The bench builds the chain with three stages of depth four, a twelve-byte buffer. At that size every fill level from empty to completely full can be swept. Each level starts from a reset, and the bench checks the per-stage full pattern against k >= D*(N-i) before draining and comparing every byte to an arithmetic sequence. The small depth also makes it cheap to reach the head-full overflow case, the exact pass-through latency of N edges, and reads of an empty chain.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic cool;
    } rxq_link_state_t;

    typedef struct packed {
        logic ovf;
    } rxq_top_state_t;

endpackage

// File: rtl/rxq_stage.sv
module rxq_stage #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             present,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    typedef struct {
        logic [WIDTH-1:0] mem [DEPTH];
        logic [PW-1:0]    rp;
        logic [PW-1:0]    wp;
        logic [CW-1:0]    cnt;
    } stage_state_t;

    stage_state_t st_d, st_q;

    logic do_push, do_pop;

    assign present = (st_q.cnt != '0);
    assign full    = (st_q.cnt == CNT_MAX);
    assign dout    = st_q.mem[st_q.rp];
    assign do_push = push && !full;
    assign do_pop  = pop && present;

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp = (st_q.wp == PTR_LAST) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == PTR_LAST) ? '0 : st_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.rp  <= '0;
            st_q.wp  <= '0;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
        st_q.mem <= st_d.mem;
    end

    // R6: a push into a full stage leaves the count unchanged unless a pop happened
    p_full_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);

    // R1: the occupancy never exceeds the depth
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_MAX);

endmodule

// File: rtl/rxq_link.sv
module rxq_link
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic src_present,
    input  logic dst_full,
    output logic move
);
    rxq_link_state_t lk_d, lk_q;

    assign move = src_present && !dst_full && !lk_q.cool;

    always_comb begin
        lk_d      = lk_q;
        lk_d.cool = move;
    end

    always_ff @(posedge clk) begin
        if (rst) lk_q <= '0;
        else     lk_q <= lk_d;
    end

    // R4: no transfer in the cycle right after a transfer
    p_no_back_to_back_r4: assert property (@(posedge clk) disable iff (rst)
        move |=> !move);

    // R3: a transfer only when the source has data and the destination has room
    p_move_legal_r3: assert property (@(posedge clk) disable iff (rst)
        move |-> (src_present && !dst_full));

endmodule

// File: rtl/rxq_cascade.sv
module rxq_cascade
    import rxq_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int STAGE_DEPTH = 16,
    parameter int NUM_STAGES  = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [WIDTH-1:0]      wr_data,
    input  logic                  rd_en,
    output logic [WIDTH-1:0]      rd_data,
    output logic                  data_avail,
    output logic [NUM_STAGES-1:0] stage_full,
    output logic                  overflow
);
    localparam int LAST = NUM_STAGES - 1;

    logic [WIDTH-1:0]      s_din  [NUM_STAGES];
    logic [WIDTH-1:0]      s_dout [NUM_STAGES];
    logic [NUM_STAGES-1:0] s_push, s_pop, s_present, s_full;

    rxq_top_state_t tp_d, tp_q;

    assign s_push[0]  = wr_en;
    assign s_din[0]   = wr_data;
    assign s_pop[LAST] = rd_en && s_present[LAST];

    generate
        for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
            rxq_stage #(.WIDTH(WIDTH), .DEPTH(STAGE_DEPTH)) u_stage (
                .clk     (clk),
                .rst     (rst),
                .push    (s_push[i]),
                .din     (s_din[i]),
                .pop     (s_pop[i]),
                .dout    (s_dout[i]),
                .present (s_present[i]),
                .full    (s_full[i])
            );
        end
        for (genvar i = 0; i < LAST; i++) begin : g_link
            logic mv;
            rxq_link u_link (
                .clk         (clk),
                .rst         (rst),
                .src_present (s_present[i]),
                .dst_full    (s_full[i+1]),
                .move        (mv)
            );
            assign s_pop[i]    = mv;
            assign s_push[i+1] = mv;
            assign s_din[i+1]  = s_dout[i];
        end
    endgenerate

    always_comb begin
        tp_d = tp_q;
        if (wr_en && s_full[0]) tp_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) tp_q <= '0;
        else     tp_q <= tp_d;
    end

    assign rd_data    = s_dout[LAST];
    assign data_avail = s_present[LAST];
    assign stage_full = s_full;
    assign overflow   = tp_q.ovf;

    // R6: overflow is sticky until reset
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R6: overflow rises only after a write meets a full head stage
    p_ovf_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(wr_en && s_full[0]));

    // R7: a read with nothing available leaves the tail empty
    p_empty_read_r7: assert property (@(posedge clk) disable iff (rst)
        (!data_avail && !s_push[LAST]) |=> !data_avail);

endmodule

// File: tb/rxq_cascade_bench.sv
module rxq_cascade_bench;
    localparam int W = 8;
    localparam int D = 4;
    localparam int N = 3;
    localparam int CAP = N * D;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [W-1:0] wr_data;
    logic         rd_en;
    logic [W-1:0] rd_data;
    logic         data_avail;
    logic [N-1:0] stage_full;
    logic         overflow;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    rxq_cascade #(.WIDTH(W), .STAGE_DEPTH(D), .NUM_STAGES(N)) u_rxq_cascade (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .data_avail(data_avail), .stage_full(stage_full),
        .overflow(overflow)
    );

    function automatic logic [W-1:0] pat(int i);
        return W'((i * 37 + 5) & 8'hff);
    endfunction

    function automatic logic [N-1:0] full_exp(int k);
        logic [N-1:0] f;
        for (int i = 0; i < N; i++) f[i] = (k >= D * (N - i));
        return f;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push_byte(logic [W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic settle();
        repeat (4 * CAP + 10) @(negedge clk);
    endtask

    task automatic pop_expect(string req, logic [W-1:0] v);
        int t = 0;
        while (!data_avail && t < 50) begin @(negedge clk); t++; end
        chk(req, {31'd0, data_avail}, 32'd1);
        chk(req, {24'd0, rd_data}, {24'd0, v});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog R8 actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        do_reset();
        // R8: reset state
        chk("R8 avail", {31'd0, data_avail}, 32'd0);
        chk("R8 full", {29'd0, stage_full}, 32'd0);
        chk("R8 ovf", {31'd0, overflow}, 32'd0);

        // R5: pass-through latency into an empty chain
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hA5;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        for (int e = 1; e < N; e++) begin
            chk("R5 early", {31'd0, data_avail}, 32'd0);
            @(negedge clk);
        end
        chk("R5 arrive", {31'd0, data_avail}, 32'd1);
        chk("R9 data", {24'd0, rd_data}, 32'hA5);

        // R1 R2 R9: sweep every fill level
        for (int k = 0; k <= CAP; k++) begin
            do_reset();
            for (int j = 0; j < k; j++) push_byte(pat(j + k));
            settle();
            chk("R1 full pattern", {29'd0, stage_full}, {29'd0, full_exp(k)});
            chk("R1 avail", {31'd0, data_avail}, {31'd0, (k > 0)});
            chk("R6 no ovf", {31'd0, overflow}, 32'd0);
            for (int j = 0; j < k; j++) pop_expect("R2 order", pat(j + k));
            settle();
            chk("R2 drained", {31'd0, data_avail}, 32'd0);
        end

        // R6: overflow on a full chain, dropped byte never appears
        do_reset();
        for (int j = 0; j < CAP; j++) push_byte(pat(j));
        settle();
        push_byte(8'hEE);
        chk("R6 ovf set", {31'd0, overflow}, 32'd1);
        chk("R6 full kept", {29'd0, stage_full}, {29'd0, full_exp(CAP)});
        for (int j = 0; j < CAP; j++) pop_expect("R6 contents", pat(j));
        settle();
        chk("R6 dropped", {31'd0, data_avail}, 32'd0);
        chk("R6 sticky", {31'd0, overflow}, 32'd1);

        // R7: reads of an empty chain do nothing
        repeat (5) begin
            @(negedge clk); rd_en = 1'b1;
            @(negedge clk); rd_en = 1'b0;
        end
        chk("R7 still empty", {31'd0, data_avail}, 32'd0);
        push_byte(8'h3C);
        push_byte(8'hC3);
        settle();
        pop_expect("R7 first", 8'h3C);
        pop_expect("R7 second", 8'hC3);
        settle();
        chk("R7 empty after", {31'd0, data_avail}, 32'd0);

        // R3 R4: burst into the head; forwarding paces itself, nothing is lost
        do_reset();
        for (int j = 0; j < D; j++) begin
            @(negedge clk); wr_en = 1'b1; wr_data = pat(j + 100);
        end
        @(negedge clk); wr_en = 1'b0;
        settle();
        chk("R3 no ovf", {31'd0, overflow}, 32'd0);
        for (int j = 0; j < D; j++) pop_expect("R4 burst order", pat(j + 100));

        // R8: reset clears overflow and content
        for (int j = 0; j < CAP + 1; j++) push_byte(pat(j));
        do_reset();
        chk("R8 ovf cleared", {31'd0, overflow}, 32'd0);
        chk("R8 emptied", {29'd0, stage_full}, 32'd0);
        chk("R8 no data", {31'd0, data_avail}, 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule